// File: doc/BRIEF.md
# Trimmable One-Hertz Tick Generator

This block turns a 32.768 kHz reference clock into a one-hertz tick. A programmable divider count sets the length of each tick period. A periodic deletion correction lengthens one period in every group of periods, which makes up for a crystal that runs fast. Both values sit in one 32-bit configuration register written from a separate processor clock domain.

Once a sticky lock bit in the register is set, the register is frozen until a hardware reset. Every processor write, whether accepted or blocked, raises a one-cycle request that tells a downstream seconds counter to advance.

A value accepted by the register crosses into the reference domain through a toggle synchronizer. The divider adopts it at the next tick boundary, so a period that is already under way is never cut short or stretched by a write.

Top module: `trim_tick_gen`

## Requirements
- R1: When the lock bit (bit 31) of the register is 0, a write stores the divider field (bits 15:0), the delete field (bits 25:16) and the lock bit from wr_data. The stored value appears on rd_data one processor clock after the write.
- R2: After reset, rd_data equals the RESET_VALUE parameter, whose default is 0x0000_7FFF. The tick period then follows the divider and delete fields of that value.
- R3: With no correction pending, tick is high for exactly one reference clock every (divider + 1) reference clocks. The first tick after reset comes on the (divider + 1)-th reference edge that sees reset low.
- R4: While the lock bit is 1, a write leaves every bit of the register unchanged, and the tick period stays the same.
- R5: The lock bit stays set until a hardware reset. After the reset, writes are accepted again.
- R6: Bits 30:26 are reserved. They always read as 0, whatever is written to them.
- R7: cnt_inc is high for exactly the one processor clock that follows each cycle with wr_en high, including writes blocked by the lock.
- R8: Ticks are numbered from 1 after reset. When the tick number is a multiple of 2^TRIM_LOG2, the period that follows it lasts (divider + 1 + delete) reference clocks. A delete value of 0 leaves every period at (divider + 1).
- R9: An accepted write changes neither the current period nor the current deletion. The new divider and delete values take effect from the first tick boundary after the value has crossed into the reference domain. The tick count used for R8 carries on across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| cnt_inc | output | 1 | One-cycle request for the seconds counter to advance, one per write |
| ref_clk | input | 1 | 32.768 kHz reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| tick | output | 1 | One-cycle tick pulse in the reference domain |

## Verification
The bench builds the block with RESET_VALUE = 0x0000_0013 and TRIM_LOG2 = 2. The out-of-reset period is therefore 20 reference clocks, and a correction lands after every fourth tick. Several corrected periods, a configuration change at a tick boundary, and the reserved-bit, lock and reset-clears-lock paths all fit within a few thousand processor clocks. The default parameters give a first tick after 32768 reference clocks and a correction after every 1024 ticks. The two synchronizer stages are kept at their default.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int REG_W    = 32;
  localparam int DIV_W    = 16;
  localparam int DIV_LSB  = 0;
  localparam int DEL_W    = 10;
  localparam int DEL_LSB  = 16;
  localparam int LOCK_BIT = 31;

  localparam logic [REG_W-1:0] FIELD_MASK =
      (REG_W'(1) << LOCK_BIT)
    | (REG_W'((1 << DEL_W) - 1) << DEL_LSB)
    | (REG_W'((1 << DIV_W) - 1) << DIV_LSB);

  typedef struct packed {
    logic [DEL_W-1:0] del;
    logic [DIV_W-1:0] div;
  } trim_cfg_t;
endpackage

// File: rtl/trim_regs.sv
module trim_regs
  import trim_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VALUE = 32'h0000_7FFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_o,
  output logic             upd_tgl_o,
  output logic             inc_o
);
  localparam logic [REG_W-1:0] RST_CFG = RESET_VALUE & FIELD_MASK;

  logic [REG_W-1:0] cfg_q;
  logic             tgl_q;
  logic             inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= RST_CFG;
      tgl_q <= 1'b0;
      inc_q <= 1'b0;
    end else begin
      inc_q <= wr_en;
      if (wr_en && !cfg_q[LOCK_BIT]) begin
        cfg_q <= wr_data & FIELD_MASK;
        tgl_q <= ~tgl_q;
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign upd_tgl_o = tgl_q;
  assign inc_o     = inc_q;
endmodule

// File: rtl/trim_sync.sv
module trim_sync
  import trim_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tgl_i,
  input  trim_cfg_t cfg_i,
  input  logic      take_i,
  output trim_cfg_t pend_cfg_o,
  output logic      pend_vld_o
);
  logic [STAGES:0] chain_q;
  logic            seen;
  trim_cfg_t       pend_q;
  logic            vld_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], tgl_i};
  end

  assign seen = chain_q[STAGES] ^ chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
    end else if (seen) begin
      pend_q <= cfg_i;
      vld_q  <= 1'b1;
    end else if (take_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign pend_cfg_o = pend_q;
  assign pend_vld_o = vld_q;
endmodule

// File: rtl/trim_divider.sv
module trim_divider
  import trim_pkg::*;
#(
  parameter int               TRIM_LOG2 = 10,
  parameter logic [DIV_W-1:0] RESET_DIV = 16'h7FFF,
  parameter logic [DEL_W-1:0] RESET_DEL = '0
) (
  input  logic      clk,
  input  logic      rst,
  input  trim_cfg_t pend_cfg_i,
  input  logic      pend_vld_i,
  output logic      take_o,
  output logic      tick_o
);
  logic [DIV_W-1:0]     cnt_q;
  logic [DIV_W-1:0]     div_q;
  logic [DEL_W-1:0]     del_q;
  logic [DEL_W-1:0]     skip_q;
  logic [TRIM_LOG2-1:0] per_q;
  logic                 tick_q;
  logic                 boundary;
  logic [DIV_W-1:0]     nxt_div;
  logic [DEL_W-1:0]     nxt_del;

  always_comb begin
    boundary = (skip_q == '0) && (cnt_q == '0);
    take_o   = boundary && pend_vld_i;
    nxt_div  = take_o ? pend_cfg_i.div : div_q;
    nxt_del  = take_o ? pend_cfg_i.del : del_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= RESET_DIV;
      div_q  <= RESET_DIV;
      del_q  <= RESET_DEL;
      skip_q <= '0;
      per_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= boundary;
      if (skip_q != '0) begin
        skip_q <= skip_q - 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= nxt_div;
        div_q <= nxt_div;
        del_q <= nxt_del;
        per_q <= per_q + 1'b1;
        if (&per_q) skip_q <= nxt_del;
      end
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/trim_tick_gen.sv
module trim_tick_gen
  import trim_pkg::*;
#(
  parameter logic [31:0] RESET_VALUE = 32'h0000_7FFF,
  parameter int          TRIM_LOG2   = 10,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        cpu_clk,
  input  logic        cpu_rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        cnt_inc,
  input  logic        ref_clk,
  input  logic        ref_rst,
  output logic        tick
);
  localparam logic [DIV_W-1:0] RST_DIV = RESET_VALUE[DIV_LSB +: DIV_W];
  localparam logic [DEL_W-1:0] RST_DEL = RESET_VALUE[DEL_LSB +: DEL_W];

  logic [REG_W-1:0] cfg;
  logic             upd_tgl;
  trim_cfg_t        cfg_x;
  trim_cfg_t        pend_cfg;
  logic             pend_vld;
  logic             take;

  trim_regs #(.RESET_VALUE(RESET_VALUE)) u_regs (
    .clk       (cpu_clk),
    .rst       (cpu_rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cfg_o     (cfg),
    .upd_tgl_o (upd_tgl),
    .inc_o     (cnt_inc)
  );

  assign cfg_x.del = cfg[DEL_LSB +: DEL_W];
  assign cfg_x.div = cfg[DIV_LSB +: DIV_W];
  assign rd_data   = cfg;

  trim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (ref_clk),
    .rst        (ref_rst),
    .tgl_i      (upd_tgl),
    .cfg_i      (cfg_x),
    .take_i     (take),
    .pend_cfg_o (pend_cfg),
    .pend_vld_o (pend_vld)
  );

  trim_divider #(
    .TRIM_LOG2 (TRIM_LOG2),
    .RESET_DIV (RST_DIV),
    .RESET_DEL (RST_DEL)
  ) u_div (
    .clk        (ref_clk),
    .rst        (ref_rst),
    .pend_cfg_i (pend_cfg),
    .pend_vld_i (pend_vld),
    .take_o     (take),
    .tick_o     (tick)
  );
endmodule

// File: rtl/trim_tick_gen_chk.sv
module trim_tick_gen_chk (
  input logic        cpu_clk,
  input logic        cpu_rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        cnt_inc
);
  p_unlocked_write_r1: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (!rd_data[31] && wr_en) |=> (rd_data[15:0] == $past(wr_data[15:0])));

  p_locked_hold_r4: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (rd_data[31] && wr_en) |=> (rd_data == $past(rd_data)));

  p_lock_sticky_r5: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    rd_data[31] |=> rd_data[31]);

  p_inc_follow_r7: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    wr_en |=> cnt_inc);

  p_inc_idle_r7: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    !wr_en |=> !cnt_inc);
endmodule

bind trim_tick_gen trim_tick_gen_chk u_chk (
  .cpu_clk (cpu_clk),
  .cpu_rst (cpu_rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .cnt_inc (cnt_inc)
);

// File: tb/tb_trim_tick_gen.sv
module tb_trim_tick_gen;
  localparam logic [31:0] RV   = 32'h0000_0013;
  localparam int          TL   = 2;
  localparam int          P    = 1 << TL;
  localparam logic [31:0] MASK = 32'h83FF_FFFF;

  logic        cpu_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        cpu_rst = 1'b1;
  logic        ref_rst = 1'b1;
  logic        wr_en   = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cnt_inc;
  logic        tick;

  trim_tick_gen #(.RESET_VALUE(RV), .TRIM_LOG2(TL), .SYNC_STAGES(2)) dut (
    .cpu_clk (cpu_clk), .cpu_rst (cpu_rst), .wr_en (wr_en), .wr_data (wr_data),
    .rd_data (rd_data), .cnt_inc (cnt_inc), .ref_clk (ref_clk), .ref_rst (ref_rst),
    .tick (tick)
  );

  always #2 cpu_clk = ~cpu_clk;
  initial begin
    #1;
    forever #7 ref_clk = ~ref_clk;
  end

  int    checks = 0;
  int    fails  = 0;
  bit    chk_en = 1'b0;
  string reg_tag = "R2";
  string tck_tag = "R2";

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // processor-side model
  logic [31:0] m_reg;
  bit          m_inc;
  int          wr_seq = 0;
  int          w_div, w_del;
  always @(posedge cpu_clk) begin
    if (cpu_rst) begin
      m_reg = RV & MASK;
      m_inc = 1'b0;
    end else begin
      m_inc = wr_en;
      if (wr_en && !m_reg[31]) begin
        m_reg  = wr_data & MASK;
        w_div  = int'(wr_data[15:0]);
        w_del  = int'(wr_data[25:16]);
        wr_seq = wr_seq + 1;
      end
    end
  end

  always @(negedge cpu_clk) begin
    if (chk_en) begin
      check(rd_data == m_reg, reg_tag, rd_data, m_reg);
      check(cnt_inc == m_inc, "R7", {31'd0, cnt_inc}, {31'd0, m_inc});
    end
  end

  // reference-side model
  int m_div, m_del, cyc, intv, nt, seen;
  bit exp_tick;
  always @(posedge ref_clk) begin
    if (ref_rst) begin
      m_div    = int'(RV[15:0]);
      m_del    = int'(RV[25:16]);
      cyc      = 0;
      intv     = m_div + 1;
      nt       = 0;
      seen     = wr_seq;
      exp_tick = 1'b0;
    end else begin
      cyc++;
      if (cyc == intv) begin
        exp_tick = 1'b1;
        nt++;
        if (seen != wr_seq) begin
          m_div = w_div;
          m_del = w_del;
          seen  = wr_seq;
        end
        intv = m_div + 1 + (((nt % P) == 0) ? m_del : 0);
        cyc  = 0;
      end else begin
        exp_tick = 1'b0;
      end
    end
  end

  always @(negedge ref_clk) begin
    if (chk_en) check(tick == exp_tick, tck_tag, {31'd0, tick}, {31'd0, exp_tick});
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge ref_clk); while (!tick);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge cpu_clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge cpu_clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  int wd = 0;
  always @(posedge cpu_clk) begin
    wd++;
    if (wd > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge ref_clk);
    @(negedge cpu_clk) cpu_rst = 1'b0;
    @(negedge ref_clk) ref_rst = 1'b0;
    chk_en = 1'b1;
    @(negedge cpu_clk);
    check(rd_data == (RV & MASK), "R2", rd_data, RV & MASK);
    check(tick == 1'b0, "R2", {31'd0, tick}, 32'd0);
    check(cnt_inc == 1'b0, "R7", {31'd0, cnt_inc}, 32'd0);
    wait_ticks(3);

    // R1 and R9: new divider with no deletion, adopted at the next boundary
    reg_tag = "R1";
    tck_tag = "R9";
    wait_ticks(1);
    do_write(32'h0000_0009);
    wait_ticks(2);
    tck_tag = "R3";
    wait_ticks(6);

    // R8: deletion of 5 cycles after every fourth tick
    tck_tag = "R9";
    wait_ticks(1);
    do_write(32'h0005_000C);
    wait_ticks(2);
    tck_tag = "R8";
    wait_ticks(10);

    // R6: reserved bits written as ones read back as zero
    reg_tag = "R6";
    wait_ticks(1);
    do_write(32'h7C03_000B);
    @(negedge cpu_clk);
    check(rd_data[30:26] == 5'd0, "R6", {27'd0, rd_data[30:26]}, 32'd0);
    wait_ticks(8);

    // R4: set lock, then try to change the register
    reg_tag = "R4";
    wait_ticks(1);
    do_write(32'h8002_000A);
    wait_ticks(4);
    do_write(32'h0000_0005);
    @(negedge cpu_clk);
    check(rd_data == 32'h8002_000A, "R4", rd_data, 32'h8002_000A);
    tck_tag = "R4";
    wait_ticks(8);

    // R5: hardware reset clears the lock
    reg_tag = "R5";
    tck_tag = "R5";
    @(negedge cpu_clk) cpu_rst = 1'b1;
    @(negedge ref_clk) ref_rst = 1'b1;
    repeat (2) @(negedge ref_clk);
    @(negedge cpu_clk) cpu_rst = 1'b0;
    @(negedge ref_clk) ref_rst = 1'b0;
    @(negedge cpu_clk);
    check(rd_data == (RV & MASK), "R5", rd_data, RV & MASK);
    wait_ticks(1);
    do_write(32'h0000_000E);
    @(negedge cpu_clk);
    check(rd_data == 32'h0000_000E, "R5", rd_data, 32'h0000_000E);
    wait_ticks(6);
    finish_run();
  end
endmodule